// File: doc/BRIEF.md
# Interrupt Table Vector Dispatcher

This block runs the firmware-side entry of an interrupt trap. When a trap is presented it records the machine status in a vector block held in memory, marks memory protection as off, and asks the interrupting device to drop its flag, unless the trap came from the memory-protect select code. It then works out where execution continues and returns that address as a new program counter with a one-cycle done pulse.

Four trap kinds exist. Timebase traps and memory-protect traps go to fixed handler words. Device and DMA-channel traps look up a per-select-code interrupt table; the sign of the table word picks between a scheduler, a device handler and an illegal-interrupt handler. The vector block base, the table base and the table length are each fetched from fixed memory words on every trap. All memory traffic uses one synchronous port with one cycle of read latency, in a fixed order.

Top module: `irq_vector_dispatch`

## Requirements
- R1: After reset `done`, `clf_stb`, `mem_we` are 0 and `new_pc` is 0.
- R2: Each trap reads the vector base V from address VB_PTR_ADDR, writes `map_status` to V+0, writes 1 to V+1 if `int_sys_on` was 0 at the trap (else 0), writes the zero-extended select code to V+2, and writes 1 to MPOFF_ADDR.
- R3: Each trap whose select code is not 5 raises `clf_stb` for exactly one cycle with `clf_sc` equal to the select code; a trap with select code 5 raises no strobe.
- R4: For table lookups the index is (select code − 6) as an unsigned W-bit value; if it is greater than the length word at TL_ADDR the entry is 0, otherwise it is the word at table base (from TB_PTR_ADDR) + index, so an index equal to the length is still read.
- R5: Trap kind encoding: device 0, DMA 1, memory protect 2, timebase 3. A device trap loads the PC from V+6 when the entry has bit 15 set, from V+5 when it is nonzero and positive, and from V+4 when it is 0.
- R6: A DMA trap clears bit 15 of the entry before that classification, so it never selects V+6.
- R7: A timebase trap loads the PC from V+3 regardless of table contents.
- R8: A memory-protect trap with `parity_err` set stores `cur_pc` at V+8 and loads the PC from V+9.
- R9: A memory-protect trap with `parity_err` clear loads the PC from V+7 and leaves V+8 unchanged.
- R10: `done` is a one-cycle pulse, exactly one per trap, and `new_pc` holds the handler word while it is high.
- R11: A trap performs exactly 4 memory writes, or 5 for a memory-protect trap with the parity flag; the parity flag has no effect on other kinds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | One-cycle trap request, only while idle |
| trap_kind | input | 2 | Trap kind (0 device, 1 DMA, 2 memory protect, 3 timebase) |
| trap_sc | input | SCW | Interrupting select code |
| parity_err | input | 1 | Parity error flag for memory-protect traps |
| map_status | input | W | Mapping status word to record |
| int_sys_on | input | 1 | Interrupt system state before the trap |
| cur_pc | input | W | Point of suspension |
| mem_addr | output | W | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | W | Memory write data |
| mem_rdata | input | W | Memory read data, one cycle after the address |
| new_pc | output | W | Handler address |
| done | output | 1 | One-cycle completion pulse |
| clf_stb | output | 1 | Clear-flag request strobe |
| clf_sc | output | SCW | Select code of the clear-flag request |

## Verification
The assertions assume a trap is only requested while the sequencer is idle, and that memory returns read data exactly one cycle after the address; the bench holds `trap_req` for a single cycle and waits for `done` plus one cycle before the next trap, and its memory model is a registered array. Stimulus mixes random kinds, select codes, table lengths and table words (zero, negative, positive and a bare sign bit) with directed cases at index equal to the length, one past it, select codes below 6, select code 5 and DMA entries with bit 15 set.

// File: rtl/ivd_pkg.sv
package ivd_pkg;

  typedef enum logic [1:0] {
    TK_DEV = 2'd0,
    TK_DMA = 2'd1,
    TK_MPV = 2'd2,
    TK_TBG = 2'd3
  } trap_kind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RVB, S_LVB, S_WMAP, S_WINT, S_WSC, S_WMPF, S_WSUS,
    S_RTL, S_LTL, S_RTB, S_LTB, S_RENT, S_LENT, S_RHND, S_LHND
  } seq_state_e;

  // word offsets inside the vector block
  localparam logic [3:0] OFS_MAP  = 4'd0;
  localparam logic [3:0] OFS_INT  = 4'd1;
  localparam logic [3:0] OFS_SC   = 4'd2;
  localparam logic [3:0] OFS_CLK  = 4'd3;
  localparam logic [3:0] OFS_ILL  = 4'd4;
  localparam logic [3:0] OFS_DEV  = 4'd5;
  localparam logic [3:0] OFS_SKD  = 4'd6;
  localparam logic [3:0] OFS_REQ  = 4'd7;
  localparam logic [3:0] OFS_SUSP = 4'd8;
  localparam logic [3:0] OFS_PERR = 4'd9;

endpackage

// File: rtl/ivd_bound.sv
module ivd_bound #(
  parameter int W       = 16,
  parameter int SCW     = 6,
  parameter int BASE_SC = 6
) (
  input  logic [SCW-1:0] sc,
  input  logic [W-1:0]   len,
  output logic [W-1:0]   idx,
  output logic           beyond
);
  // select codes below the base wrap to large values and fall outside
  assign idx    = W'(sc) - W'(BASE_SC);
  assign beyond = (idx > len);
endmodule

// File: rtl/ivd_classify.sv
module ivd_classify #(
  parameter int W = 16
) (
  input  logic [W-1:0] entry,
  output logic [3:0]   ofs
);
  import ivd_pkg::*;
  always_comb begin
    if (entry[W-1])     ofs = OFS_SKD;
    else if (|entry)    ofs = OFS_DEV;
    else                ofs = OFS_ILL;
  end
endmodule

// File: rtl/ivd_memport.sv
module ivd_memport
  import ivd_pkg::*;
#(
  parameter int           W           = 16,
  parameter int           SCW         = 6,
  parameter logic [W-1:0] VB_PTR_ADDR = 16'h0010,
  parameter logic [W-1:0] TB_PTR_ADDR = 16'h0011,
  parameter logic [W-1:0] TL_ADDR     = 16'h0012,
  parameter logic [W-1:0] MPOFF_ADDR  = 16'h0013
) (
  input  seq_state_e     st,
  input  trap_kind_e     kind,
  input  logic           par,
  input  logic [3:0]     class_ofs,
  input  logic [W-1:0]   vbase,
  input  logic [W-1:0]   tbase,
  input  logic [W-1:0]   idx,
  input  logic [W-1:0]   map_word,
  input  logic           intoff,
  input  logic [SCW-1:0] sc,
  input  logic [W-1:0]   pc,
  output logic [W-1:0]   addr,
  output logic           we,
  output logic [W-1:0]   wdata
);
  logic [3:0] hoff;

  function automatic logic [W-1:0] vslot(input logic [W-1:0] b, input logic [3:0] o);
    return b + {{(W-4){1'b0}}, o};
  endfunction

  always_comb begin
    case (kind)
      TK_TBG:  hoff = OFS_CLK;
      TK_MPV:  hoff = par ? OFS_PERR : OFS_REQ;
      default: hoff = class_ofs;
    endcase
  end

  always_comb begin
    addr  = '0;
    we    = 1'b0;
    wdata = '0;
    case (st)
      S_RVB:  addr = VB_PTR_ADDR;
      S_WMAP: begin addr = vslot(vbase, OFS_MAP);  we = 1'b1; wdata = map_word; end
      S_WINT: begin addr = vslot(vbase, OFS_INT);  we = 1'b1; wdata = {{(W-1){1'b0}}, intoff}; end
      S_WSC:  begin addr = vslot(vbase, OFS_SC);   we = 1'b1; wdata = {{(W-SCW){1'b0}}, sc}; end
      S_WMPF: begin addr = MPOFF_ADDR;             we = 1'b1; wdata = {{(W-1){1'b0}}, 1'b1}; end
      S_WSUS: begin addr = vslot(vbase, OFS_SUSP); we = 1'b1; wdata = pc; end
      S_RTL:  addr = TL_ADDR;
      S_RTB:  addr = TB_PTR_ADDR;
      S_RENT: addr = tbase + idx;
      S_RHND: addr = vslot(vbase, hoff);
      default: ;
    endcase
  end
endmodule

// File: rtl/ivd_fsm.sv
module ivd_fsm
  import ivd_pkg::*;
#(
  parameter int W     = 16,
  parameter int SCW   = 6,
  parameter int MP_SC = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           trap_req,
  input  logic [1:0]     trap_kind,
  input  logic [SCW-1:0] trap_sc,
  input  logic           parity_err,
  input  logic [W-1:0]   map_status,
  input  logic           int_sys_on,
  input  logic [W-1:0]   cur_pc,
  input  logic [W-1:0]   mem_rdata,
  input  logic           beyond,
  output seq_state_e     st,
  output trap_kind_e     kind_q,
  output logic [SCW-1:0] sc_q,
  output logic           par_q,
  output logic [W-1:0]   map_q,
  output logic           intoff_q,
  output logic [W-1:0]   pc_q,
  output logic [W-1:0]   vbase_q,
  output logic [W-1:0]   tbase_q,
  output logic [W-1:0]   len_q,
  output logic [W-1:0]   entry_q,
  output logic [W-1:0]   new_pc,
  output logic           done,
  output logic           clf_stb,
  output logic [SCW-1:0] clf_sc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      kind_q   <= TK_DEV;
      sc_q     <= '0;
      par_q    <= 1'b0;
      map_q    <= '0;
      intoff_q <= 1'b0;
      pc_q     <= '0;
      vbase_q  <= '0;
      tbase_q  <= '0;
      len_q    <= '0;
      entry_q  <= '0;
      new_pc   <= '0;
      done     <= 1'b0;
      clf_stb  <= 1'b0;
      clf_sc   <= '0;
    end else begin
      done    <= 1'b0;
      clf_stb <= 1'b0;
      case (st)
        S_IDLE: if (trap_req) begin
          kind_q   <= trap_kind_e'(trap_kind);
          sc_q     <= trap_sc;
          par_q    <= parity_err;
          map_q    <= map_status;
          intoff_q <= ~int_sys_on;
          pc_q     <= cur_pc;
          entry_q  <= '0;
          st       <= S_RVB;
        end
        S_RVB:  st <= S_LVB;
        S_LVB:  begin vbase_q <= mem_rdata; st <= S_WMAP; end
        S_WMAP: st <= S_WINT;
        S_WINT: st <= S_WSC;
        S_WSC: begin
          clf_stb <= (sc_q != SCW'(MP_SC));
          clf_sc  <= sc_q;
          st      <= S_WMPF;
        end
        S_WMPF: begin
          case (kind_q)
            TK_TBG:  st <= S_RHND;
            TK_MPV:  st <= par_q ? S_WSUS : S_RHND;
            default: st <= S_RTL;
          endcase
        end
        S_WSUS: st <= S_RHND;
        S_RTL:  st <= S_LTL;
        S_LTL:  begin len_q <= mem_rdata; st <= S_RTB; end
        S_RTB:  st <= S_LTB;
        S_LTB: begin
          tbase_q <= mem_rdata;
          if (beyond) begin
            entry_q <= '0;
            st      <= S_RHND;
          end else begin
            st <= S_RENT;
          end
        end
        S_RENT: st <= S_LENT;
        S_LENT: begin
          entry_q <= (kind_q == TK_DMA) ? {1'b0, mem_rdata[W-2:0]} : mem_rdata;
          st      <= S_RHND;
        end
        S_RHND: st <= S_LHND;
        S_LHND: begin
          new_pc <= mem_rdata;
          done   <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_vector_dispatch.sv
module irq_vector_dispatch
  import ivd_pkg::*;
#(
  parameter int           W           = 16,
  parameter int           SCW         = 6,
  parameter int           BASE_SC     = 6,
  parameter int           MP_SC       = 5,
  parameter logic [W-1:0] VB_PTR_ADDR = 16'h0010,
  parameter logic [W-1:0] TB_PTR_ADDR = 16'h0011,
  parameter logic [W-1:0] TL_ADDR     = 16'h0012,
  parameter logic [W-1:0] MPOFF_ADDR  = 16'h0013
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           trap_req,
  input  logic [1:0]     trap_kind,
  input  logic [SCW-1:0] trap_sc,
  input  logic           parity_err,
  input  logic [W-1:0]   map_status,
  input  logic           int_sys_on,
  input  logic [W-1:0]   cur_pc,
  output logic [W-1:0]   mem_addr,
  output logic           mem_we,
  output logic [W-1:0]   mem_wdata,
  input  logic [W-1:0]   mem_rdata,
  output logic [W-1:0]   new_pc,
  output logic           done,
  output logic           clf_stb,
  output logic [SCW-1:0] clf_sc
);
  seq_state_e     st;
  trap_kind_e     kind_q;
  logic [SCW-1:0] sc_q;
  logic           par_q, intoff_q, beyond;
  logic [W-1:0]   map_q, pc_q, vbase_q, tbase_q, len_q, entry_q, idx;
  logic [3:0]     class_ofs;

  ivd_fsm #(.W(W), .SCW(SCW), .MP_SC(MP_SC)) u_fsm (
    .clk(clk), .rst(rst), .trap_req(trap_req), .trap_kind(trap_kind),
    .trap_sc(trap_sc), .parity_err(parity_err), .map_status(map_status),
    .int_sys_on(int_sys_on), .cur_pc(cur_pc), .mem_rdata(mem_rdata),
    .beyond(beyond), .st(st), .kind_q(kind_q), .sc_q(sc_q), .par_q(par_q),
    .map_q(map_q), .intoff_q(intoff_q), .pc_q(pc_q), .vbase_q(vbase_q),
    .tbase_q(tbase_q), .len_q(len_q), .entry_q(entry_q), .new_pc(new_pc),
    .done(done), .clf_stb(clf_stb), .clf_sc(clf_sc)
  );

  ivd_bound #(.W(W), .SCW(SCW), .BASE_SC(BASE_SC)) u_bound (
    .sc(sc_q), .len(len_q), .idx(idx), .beyond(beyond)
  );

  ivd_classify #(.W(W)) u_class (
    .entry(entry_q), .ofs(class_ofs)
  );

  ivd_memport #(
    .W(W), .SCW(SCW), .VB_PTR_ADDR(VB_PTR_ADDR), .TB_PTR_ADDR(TB_PTR_ADDR),
    .TL_ADDR(TL_ADDR), .MPOFF_ADDR(MPOFF_ADDR)
  ) u_port (
    .st(st), .kind(kind_q), .par(par_q), .class_ofs(class_ofs),
    .vbase(vbase_q), .tbase(tbase_q), .idx(idx), .map_word(map_q),
    .intoff(intoff_q), .sc(sc_q), .pc(pc_q),
    .addr(mem_addr), .we(mem_we), .wdata(mem_wdata)
  );
endmodule

// File: rtl/ivd_chk.sv
module ivd_chk
  import ivd_pkg::*;
#(
  parameter int           W          = 16,
  parameter int           SCW        = 6,
  parameter int           MP_SC      = 5,
  parameter logic [W-1:0] MPOFF_ADDR = 16'h0013
) (
  input logic           clk,
  input logic           rst,
  input logic           trap_req,
  input logic           done,
  input logic           clf_stb,
  input logic [SCW-1:0] clf_sc,
  input logic           mem_we,
  input logic [W-1:0]   mem_addr,
  input logic [W-1:0]   mem_wdata,
  input seq_state_e     st
);
  AST_TRAP_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> st == S_IDLE);                                         // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                                    // R10
  AST_CLF_SINGLE: assert property (@(posedge clk) disable iff (rst)
    clf_stb |=> !clf_stb);                                              // R3
  AST_CLF_NOT_PROTECT: assert property (@(posedge clk) disable iff (rst)
    clf_stb |-> clf_sc != SCW'(MP_SC));                                 // R3
  AST_MPOFF_VALUE: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_addr == MPOFF_ADDR) |-> mem_wdata == W'(1));         // R2
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) |-> !mem_we);                                        // R11
endmodule

bind irq_vector_dispatch ivd_chk #(
  .W(W), .SCW(SCW), .MP_SC(MP_SC), .MPOFF_ADDR(MPOFF_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .trap_req(trap_req), .done(done),
  .clf_stb(clf_stb), .clf_sc(clf_sc), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .st(st)
);

// File: tb/irq_vector_dispatch_test.sv
`timescale 1ns/1ps
module irq_vector_dispatch_test;
  localparam logic [15:0] VBP = 16'h0010, TBP = 16'h0011, TLA = 16'h0012, MPF = 16'h0013;
  localparam logic [15:0] VBASE = 16'h0040, TBASE = 16'h0100;

  logic clk = 0, rst = 1;
  logic trap_req = 0, parity_err = 0, int_sys_on = 0;
  logic [1:0] trap_kind = 0;
  logic [5:0] trap_sc = 0;
  logic [15:0] map_status = 0, cur_pc = 0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, new_pc;
  logic mem_we, done, clf_stb;
  logic [5:0] clf_sc;

  logic [15:0] mem [0:1023];
  int tests = 0, fails = 0;
  int wr_cnt = 0, done_cnt = 0, clf_cnt = 0;
  logic [5:0] clf_last = 0;

  always #10 clk = ~clk;

  irq_vector_dispatch #(.VB_PTR_ADDR(VBP), .TB_PTR_ADDR(TBP), .TL_ADDR(TLA),
                        .MPOFF_ADDR(MPF)) uut (
    .clk(clk), .rst(rst), .trap_req(trap_req), .trap_kind(trap_kind),
    .trap_sc(trap_sc), .parity_err(parity_err), .map_status(map_status),
    .int_sys_on(int_sys_on), .cur_pc(cur_pc), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .new_pc(new_pc), .done(done), .clf_stb(clf_stb), .clf_sc(clf_sc));

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[9:0]];
  end

  always @(negedge clk) begin
    if (mem_we) wr_cnt++;
    if (done) done_cnt++;
    if (clf_stb) begin clf_cnt++; clf_last = clf_sc; end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rnd_entry();
    case ($urandom % 4)
      0: return 16'h0000;
      1: return 16'h8000 | 16'($urandom);
      2: return (16'($urandom) & 16'h7FFF) | 16'h0001;
      default: return 16'h8000;
    endcase
  endfunction

  task automatic prep(input logic [15:0] len);
    mem[VBP[9:0]] = VBASE;
    mem[TBP[9:0]] = TBASE;
    mem[TLA[9:0]] = len;
    mem[MPF[9:0]] = 16'h0000;
    for (int k = 0; k < 10; k++) mem[VBASE[9:0] + k] = {4'(k), 12'($urandom)};
    for (int k = 0; k < 3; k++) mem[VBASE[9:0] + k] = 16'hFFFF;
    mem[VBASE[9:0] + 8] = 16'hDEAD;
    for (int i = 0; i < 80; i++) mem[TBASE[9:0] + i] = rnd_entry();
  endtask

  function automatic logic [15:0] exp_pc(input logic [1:0] k, input logic [5:0] sc,
                                         input bit par);
    logic [15:0] idx, ent, len;
    logic [3:0] o;
    len = mem[TLA[9:0]];
    idx = 16'(sc) - 16'd6;
    ent = (idx > len) ? 16'h0 : mem[TBASE[9:0] + idx[9:0]];
    if (k == 2'd1) ent[15] = 1'b0;
    case (k)
      2'd3: o = 4'd3;
      2'd2: o = par ? 4'd9 : 4'd7;
      default: o = ent[15] ? 4'd6 : (ent != 0 ? 4'd5 : 4'd4);
    endcase
    return mem[VBASE[9:0] + o];
  endfunction

  task automatic fire(input logic [1:0] k, input logic [5:0] sc, input bit par,
                      input bit ion, input string pctag);
    logic [15:0] ep, mp, pc;
    int n;
    ep = exp_pc(k, sc, par);
    mp = 16'($urandom);
    pc = 16'($urandom) & 16'h7FFF;
    @(negedge clk);
    wr_cnt = 0; done_cnt = 0; clf_cnt = 0;
    trap_req = 1; trap_kind = k; trap_sc = sc; parity_err = par;
    int_sys_on = ion; map_status = mp; cur_pc = pc;
    @(negedge clk);
    trap_req = 0;
    n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    chk(done == 1'b1, "R10", "done seen", 16'(done), 16'h1);
    chk(new_pc == ep, pctag, "new_pc", new_pc, ep);
    @(negedge clk);
    chk(done_cnt == 1, "R10", "done pulses", 16'(done_cnt), 16'h1);
    chk(mem[VBASE[9:0]] == mp, "R2", "map word", mem[VBASE[9:0]], mp);
    chk(mem[VBASE[9:0] + 1] == 16'(!ion), "R2", "int word", mem[VBASE[9:0] + 1], 16'(!ion));
    chk(mem[VBASE[9:0] + 2] == 16'(sc), "R2", "sc word", mem[VBASE[9:0] + 2], 16'(sc));
    chk(mem[MPF[9:0]] == 16'h1, "R2", "mp-off flag", mem[MPF[9:0]], 16'h1);
    if (sc == 6'd5) chk(clf_cnt == 0, "R3", "clf count sc5", 16'(clf_cnt), 16'h0);
    else begin
      chk(clf_cnt == 1, "R3", "clf count", 16'(clf_cnt), 16'h1);
      chk(clf_last == sc, "R3", "clf sc", 16'(clf_last), 16'(sc));
    end
    if (k == 2'd2 && par) begin
      chk(mem[VBASE[9:0] + 8] == pc, "R8", "suspension", mem[VBASE[9:0] + 8], pc);
      chk(wr_cnt == 5, "R11", "writes", 16'(wr_cnt), 16'd5);
    end else begin
      chk(mem[VBASE[9:0] + 8] == 16'hDEAD, "R9", "slot untouched", mem[VBASE[9:0] + 8], 16'hDEAD);
      chk(wr_cnt == 4, "R11", "writes", 16'(wr_cnt), 16'd4);
    end
  endtask

  function automatic string tag_of(input logic [1:0] k, input bit par);
    case (k)
      2'd0: return "R5";
      2'd1: return "R6";
      2'd2: return par ? "R8" : "R9";
      default: return "R7";
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(done == 0 && clf_stb == 0, "R1", "reset strobes", {14'h0, done, clf_stb}, 16'h0);
    chk(mem_we == 0, "R1", "reset write", 16'(mem_we), 16'h0);
    chk(new_pc == 0, "R1", "reset pc", new_pc, 16'h0);

    // R4 index equal to length is read
    prep(16'd3); mem[TBASE[9:0] + 3] = 16'h1234; fire(2'd0, 6'd9, 0, 1, "R4");
    // R4 index one past length gives illegal
    prep(16'd3); mem[TBASE[9:0] + 4] = 16'h1234; fire(2'd0, 6'd10, 0, 0, "R4");
    // R4 select code below base wraps out of range
    prep(16'd40); fire(2'd0, 6'd3, 0, 1, "R4");
    // R5 negative entry selects scheduler
    prep(16'd10); mem[TBASE[9:0]] = 16'h8001; fire(2'd0, 6'd6, 0, 1, "R5");
    // R6 DMA with bare sign bit becomes zero
    prep(16'd10); mem[TBASE[9:0] + 1] = 16'h8000; fire(2'd1, 6'd7, 0, 1, "R6");
    // R6 DMA negative entry becomes positive
    prep(16'd10); mem[TBASE[9:0] + 1] = 16'h8123; fire(2'd1, 6'd7, 0, 0, "R6");
    // R3 memory-protect select code issues no strobe, R9 no parity
    prep(16'd10); fire(2'd2, 6'd5, 0, 1, "R9");
    // R8 parity
    prep(16'd10); fire(2'd2, 6'd5, 1, 0, "R8");
    // R7 timebase, R11 parity ignored on other kinds
    prep(16'd10); fire(2'd3, 6'd11, 1, 1, "R7");
    prep(16'd10); fire(2'd0, 6'd8, 1, 1, "R11");

    for (int t = 0; t < 300; t++) begin
      logic [1:0] k;
      logic [5:0] sc;
      bit par;
      k = 2'($urandom);
      sc = 6'($urandom);
      par = 1'($urandom);
      prep(16'($urandom % 72));
      fire(k, sc, par, 1'($urandom), tag_of(k, par));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule